// File: doc/BRIEF.md
# Synchronous Exception and Cause/EPC Unit

This unit holds the exception logic of a 32-bit single-cycle load/store processor. In every cycle it looks at the decoder's legality flag and at the signed overflow flag from the ALU. It decides whether the instruction now executing must trap.

When a trap occurs, the unit does four things:
- It stores a numeric cause code.
- It stores the address of the faulting instruction.
- It steers the next program counter to a fixed handler entry.
- It blocks the instruction's register-file and data-memory writes in that same cycle.

The unit also serves the move-from-coprocessor-0 instruction. That instruction reads back the cause or exception-PC register by index, and the datapath writes the result into a general register. Both registers sit outside the general register file.

Top module: `exc_unit`

## Requirements
- R1: A synchronous active-high reset clears both the cause register and the exception-PC register to 0, so reads at index 13 and index 14 return 0.
- R2: An instruction with `op_legal` low traps, and after the clock edge the cause register holds 40 (0x28).
- R3: A legal instruction with both `ovf_check` and `alu_ovf` high traps, and after the clock edge the cause register holds 48 (0x30).
- R4: On any trap, the exception-PC register captures `cur_pc` of the faulting instruction. It does not capture the sequential next address.
- R5: `pc_next` equals 0x80000180 in a trapping cycle and equals `seq_pc` in every other cycle.
- R6: In a trapping cycle, `rf_we` and `dm_we` are both 0. In every other cycle they follow `rf_we_req` and `dm_we_req`.
- R7: When `op_legal` is low and `ovf_check` and `alu_ovf` are both high, the recorded cause is 40, not 48.
- R8: `c0_rdata` returns the cause register when `c0_sel` is 13, the exception-PC register when `c0_sel` is 14, and 0 for every other index.
- R9: In a cycle with no trap, both registers keep their values. `alu_ovf` alone causes no trap when `ovf_check` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | Address of the instruction now executing |
| seq_pc | input | 32 | Next address chosen by the normal datapath |
| op_legal | input | 1 | Decoder recognised the opcode/function field |
| ovf_check | input | 1 | Instruction is a signed add, subtract or add-immediate |
| alu_ovf | input | 1 | ALU signed overflow flag |
| c0_sel | input | 5 | Coprocessor-0 register index for the read |
| rf_we_req | input | 1 | Register write requested by the decoder |
| dm_we_req | input | 1 | Memory write requested by the decoder |
| pc_next | output | 32 | Program counter for the next cycle |
| c0_rdata | output | 32 | Coprocessor-0 read data |
| rf_we | output | 1 | Register write after squashing |
| dm_we | output | 1 | Memory write after squashing |
| trap | output | 1 | An exception is taken this cycle |

## Verification
The bench sweeps every combination of the legality flag, the overflow qualifier, the overflow flag and the two write requests. It moves the PC each cycle, so a stale exception PC shows up at once. A priority inversion would record 48 for an undefined instruction that also raises overflow. A unit that does not qualify overflow would trap on unchecked instructions and redirect their PC. A unit that stores the sequential address would return `seq_pc` instead of the faulting PC from index 14. The bench also sweeps all 32 read indices, which catches an aliased decode or a nonzero result for an unmapped index.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned IDX_W = 5;
  localparam logic [XLEN-1:0] CODE_UNDEF = 32'd40;
  localparam logic [XLEN-1:0] CODE_OVF   = 32'd48;
  localparam logic [IDX_W-1:0] IDX_CAUSE = 5'd13;
  localparam logic [IDX_W-1:0] IDX_EPC   = 5'd14;
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
(
  input  logic            op_legal,
  input  logic            ovf_check,
  input  logic            alu_ovf,
  output logic            take,
  output logic [XLEN-1:0] code
);
  logic ovf_hit;

  always_comb begin
    ovf_hit = op_legal & ovf_check & alu_ovf;
    take    = ~op_legal | ovf_hit;
    // undefined decode outranks overflow
    code    = (~op_legal) ? CODE_UNDEF : CODE_OVF;
  end
endmodule

// File: rtl/exc_c0regs.sv
module exc_c0regs
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [XLEN-1:0]  code,
  input  logic [XLEN-1:0]  fault_pc,
  input  logic [IDX_W-1:0] sel,
  output logic [XLEN-1:0]  cause_q,
  output logic [XLEN-1:0]  epc_q,
  output logic [XLEN-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
    end else if (take) begin
      cause_q <= code;
      epc_q   <= fault_pc;
    end
  end

  always_comb begin
    unique case (sel)
      IDX_CAUSE: rdata = cause_q;
      IDX_EPC:   rdata = epc_q;
      default:   rdata = '0;
    endcase
  end

  AST_HOLD_REGS: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(cause_q) && $stable(epc_q))); // R9
  AST_EPC_FAULT: assert property (@(posedge clk) disable iff (rst)
    take |=> (epc_q == $past(fault_pc))); // R4
endmodule

// File: rtl/exc_pcsel.sv
module exc_pcsel
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER = 32'h8000_0180
) (
  input  logic            take,
  input  logic [XLEN-1:0] seq_pc,
  input  logic            rf_we_req,
  input  logic            dm_we_req,
  output logic [XLEN-1:0] pc_next,
  output logic            rf_we,
  output logic            dm_we
);
  always_comb begin
    pc_next = take ? HANDLER : seq_pc;
    rf_we   = rf_we_req & ~take;
    dm_we   = dm_we_req & ~take;
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] HANDLER = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] cur_pc,
  input  logic [31:0] seq_pc,
  input  logic        op_legal,
  input  logic        ovf_check,
  input  logic        alu_ovf,
  input  logic [4:0]  c0_sel,
  input  logic        rf_we_req,
  input  logic        dm_we_req,
  output logic [31:0] pc_next,
  output logic [31:0] c0_rdata,
  output logic        rf_we,
  output logic        dm_we,
  output logic        trap
);
  logic [XLEN-1:0] code;
  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] epc_q;

  exc_detect u_det (
    .op_legal(op_legal), .ovf_check(ovf_check), .alu_ovf(alu_ovf),
    .take(trap), .code(code)
  );

  exc_c0regs u_regs (
    .clk(clk), .rst(rst), .take(trap), .code(code), .fault_pc(cur_pc),
    .sel(c0_sel), .cause_q(cause_q), .epc_q(epc_q), .rdata(c0_rdata)
  );

  exc_pcsel #(.HANDLER(HANDLER)) u_pc (
    .take(trap), .seq_pc(seq_pc), .rf_we_req(rf_we_req),
    .dm_we_req(dm_we_req), .pc_next(pc_next), .rf_we(rf_we), .dm_we(dm_we)
  );

  AST_UNDEF_CODE: assert property (@(posedge clk) disable iff (rst)
    !op_legal |=> (cause_q == CODE_UNDEF)); // R2
  AST_OVF_CODE: assert property (@(posedge clk) disable iff (rst)
    (op_legal && ovf_check && alu_ovf) |=> (cause_q == CODE_OVF)); // R3
  AST_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    (!op_legal || (ovf_check && alu_ovf)) |-> (pc_next == HANDLER)); // R5
  AST_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (!op_legal || (ovf_check && alu_ovf)) |-> (!rf_we && !dm_we)); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (op_legal && !ovf_check) |-> (!trap && pc_next == seq_pc)); // R9
endmodule

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cur_pc, seq_pc;
  logic        op_legal, ovf_check, alu_ovf, rf_we_req, dm_we_req;
  logic [4:0]  c0_sel;
  logic [31:0] pc_next, c0_rdata;
  logic        rf_we, dm_we, trap;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_cause, m_epc;
  bit done = 0;

  localparam logic [31:0] HANDLER = 32'h8000_0180;

  always #4 clk = ~clk;

  exc_unit u0 (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .seq_pc(seq_pc),
    .op_legal(op_legal), .ovf_check(ovf_check), .alu_ovf(alu_ovf),
    .c0_sel(c0_sel), .rf_we_req(rf_we_req), .dm_we_req(dm_we_req),
    .pc_next(pc_next), .c0_rdata(c0_rdata), .rf_we(rf_we), .dm_we(dm_we),
    .trap(trap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] s);
    if (s == 5'd13) return m_cause;
    if (s == 5'd14) return m_epc;
    return 32'd0;
  endfunction

  task automatic step(input logic lg, input logic oc, input logic ov,
                      input logic rw, input logic mw, input logic [31:0] pc,
                      input logic [4:0] sel);
    logic tk;
    logic [31:0] code;
    @(negedge clk);
    op_legal = lg; ovf_check = oc; alu_ovf = ov;
    rf_we_req = rw; dm_we_req = mw; cur_pc = pc; seq_pc = pc + 32'd4;
    c0_sel = sel;
    #1;
    tk = !lg || (oc && ov);
    code = !lg ? 32'd40 : 32'd48;
    check("R5 pc_next", pc_next, tk ? HANDLER : pc + 32'd4);
    check("R6 rf_we", {31'd0, rf_we}, {31'd0, rw & ~tk});
    check("R6 dm_we", {31'd0, dm_we}, {31'd0, mw & ~tk});
    check("R9 trap", {31'd0, trap}, {31'd0, tk});
    check("R8 c0_rdata", c0_rdata, model_read(sel));
    @(posedge clk);
    if (tk) begin m_cause = code; m_epc = pc; end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cur_pc = 0; seq_pc = 4; op_legal = 1; ovf_check = 0;
    alu_ovf = 0; rf_we_req = 0; dm_we_req = 0; c0_sel = 5'd13;
    m_cause = 0; m_epc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 cause after reset", c0_rdata, 32'd0);
    c0_sel = 5'd14; #1;
    check("R1 epc after reset", c0_rdata, 32'd0);

    // R2 R3 R7 R4: sweep all flag combinations, twice with moving PCs
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 32; k++) begin
        logic [31:0] pc;
        pc = 32'h0040_0000 + 32'(pass * 1024 + k * 4);
        step(~k[0], k[1], k[2], k[3], k[4], pc, (k % 2 == 0) ? 5'd13 : 5'd14);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pc + 32'h100, 5'd13);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, pc + 32'h104, 5'd14);
      end
    end

    // R7: both conditions at once, cause must be 40
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1230, 5'd13);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1234, 5'd13);
    check("R7 priority cause", c0_rdata, 32'd40);
    // R3 then R4
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 5'd0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2004, 5'd13);
    check("R3 overflow cause", c0_rdata, 32'd48);
    c0_sel = 5'd14; #1;
    check("R4 epc holds faulting pc", c0_rdata, 32'h0000_2000);

    // R8: sweep every index
    for (int s = 0; s < 32; s++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_3000 + 32'(s * 4), 5'(s));
    end

    // R1: reset again clears state
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0; m_cause = 0; m_epc = 0;
    c0_sel = 5'd13; #1;
    check("R1 cause after second reset", c0_rdata, 32'd0);
    c0_sel = 5'd14; #1;
    check("R1 epc after second reset", c0_rdata, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule